// File: doc/BRIEF.md
# Direct-Mapped Write-Back Cache Controller

This block is the control half of a small byte-wide data cache placed between a synchronous processor and a main-memory controller. It keeps, per cache line, a stored tag, a valid flag and a dirty flag. It drives an external single-port line RAM with one cycle of read latency. Read and write hits are served directly from that RAM. A miss first copies a modified victim line out to main memory, then loads the requested line, and then finishes the original access exactly as a hit.

The processor places its address, direction and write data on the bus and then holds its strobe high for four cycles. The controller takes the request on the strobe's rising edge and lowers its ready output until the whole operation is done. Main memory is reached over a byte-wide request/acknowledge handshake. Each acknowledge completes one byte. A request still high in the cycle after an acknowledge is a new transfer, to the address presented in that cycle.

Top module: `dmc_cache_ctrl`

## Requirements
- R1: After reset the ready output is high, no memory request is raised, and every line is invalid, so the first access to any index fetches a whole line.
- R2: A 16-bit address splits into tag = bits 15:8, line index = bits 7:5 and byte offset = bits 4:0. Line RAM addresses are {index, offset}, and line transfers use memory base {tag, index, 5'b00000}.
- R3: A request is accepted only on a rising strobe while ready is high. Ready is low in the following cycle and stays low until the operation ends. A strobe still held after completion starts nothing new.
- R4: A write hit stores the byte in the line RAM and marks the line dirty, with no memory traffic.
- R5: A read hit returns the byte at {index, offset}, valid once ready returns, with no memory traffic.
- R6: A miss on a clean or invalid line reads 32 bytes from main memory at ascending offsets 0 to 31 of the new base and writes them into the line RAM. The controller then stores the new tag and marks the line valid and clean.
- R7: A miss on a dirty line first writes all 32 resident bytes, in ascending offset order, to the base rebuilt from the stored tag. The refill starts only after that.
- R8: On a write miss the processor byte is merged only after the refill, so the written byte and the refilled neighbours are all visible afterwards.
- R9: A memory request keeps its address, direction and write data steady until it is acknowledged.
- R10: A write hit raises ready again 2 cycles after acceptance, and a read hit does so after 3 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_cs | input | 1 | Processor strobe, held 4 cycles |
| cpu_wr | input | 1 | Direction: 1 = write, 0 = read |
| cpu_addr | input | 16 | Processor byte address |
| cpu_wdata | input | 8 | Processor write byte |
| cpu_rdata | output | 8 | Read result, valid when ready returns |
| cpu_rdy | output | 1 | High while idle, low while busy |
| mem_req | output | 1 | Main-memory transfer request |
| mem_we | output | 1 | Transfer direction: 1 = write |
| mem_addr | output | 16 | Main-memory byte address |
| mem_wdata | output | 8 | Write-back byte |
| mem_rdata | input | 8 | Refill byte, valid with acknowledge |
| mem_ack | input | 1 | One-cycle completion of a transfer |
| ram_addr | output | 8 | Line RAM address {index, offset} |
| ram_din | output | 8 | Line RAM write data |
| ram_wen | output | 1 | Line RAM write enable |
| ram_dout | input | 8 | Line RAM read data, one cycle after address |

## Verification
Several properties are checked on every cycle by assertions. Ready must fall after an accepted strobe. A memory request must hold steady until acknowledged. The line RAM must never be written during a write-back. Each refilled byte must land at the RAM offset that matches its memory offset. The tag store must show a valid, clean line after a fill and a dirty line after a write hit. The hit latencies are also asserted. Other properties only show up in the bench's scenarios against a reference memory and a reference tag model: whether a dirty line's contents reach memory intact, the ordering and base of each 32-byte burst, the merge of a write miss after the refill, and the absence of a retrigger from a held strobe.

// File: rtl/dmc_pkg.sv
package dmc_pkg;
  typedef enum logic [2:0] {
    S_IDLE  = 3'd0,
    S_LOOK  = 3'd1,
    S_RDCAP = 3'd2,
    S_WBPRE = 3'd3,
    S_WBREQ = 3'd4,
    S_FILL  = 3'd5
  } ctl_state_e;
endpackage

// File: rtl/dmc_tag_store.sv
module dmc_tag_store #(
  parameter int TAG_W = 8,
  parameter int IDX_W = 3,
  localparam int LINES = 1 << IDX_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [TAG_W-1:0] rd_tag,
  output logic             rd_valid,
  output logic             rd_dirty,
  input  logic             fill_en,
  input  logic [IDX_W-1:0] fill_idx,
  input  logic [TAG_W-1:0] fill_tag,
  input  logic             mark_en,
  input  logic [IDX_W-1:0] mark_idx
);
  logic [LINES-1:0] valid_q;
  logic [LINES-1:0] dirty_q;
  logic [TAG_W-1:0] tag_q [LINES];

  for (genvar g = 0; g < LINES; g++) begin : g_line
    logic fill_hit;
    logic mark_hit;
    assign fill_hit = fill_en && (fill_idx == IDX_W'(g));
    assign mark_hit = mark_en && (mark_idx == IDX_W'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        valid_q[g] <= 1'b0;
        dirty_q[g] <= 1'b0;
      end else if (fill_hit) begin
        valid_q[g] <= 1'b1;
        dirty_q[g] <= 1'b0;
      end else if (mark_hit) begin
        dirty_q[g] <= 1'b1;
      end
    end

    always_ff @(posedge clk) begin
      if (fill_hit) tag_q[g] <= fill_tag;
    end
  end

  assign rd_tag   = tag_q[rd_idx];
  assign rd_valid = valid_q[rd_idx];
  assign rd_dirty = dirty_q[rd_idx];

  assert_fill_clean_R6: assert property (@(posedge clk) disable iff (!rst_n)
    fill_en |=> valid_q[$past(fill_idx)] && !dirty_q[$past(fill_idx)]);
  assert_mark_dirty_R4: assert property (@(posedge clk) disable iff (!rst_n)
    mark_en |=> dirty_q[$past(mark_idx)]);
  assert_mark_on_valid_R4: assert property (@(posedge clk) disable iff (!rst_n)
    mark_en |-> valid_q[mark_idx]);
endmodule

// File: rtl/dmc_beat_cnt.sv
module dmc_beat_cnt #(
  parameter int W = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] cnt,
  output logic         last
);
  logic [W-1:0] cnt_q;
  logic [W-1:0] cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (clr)      cnt_d = '0;
    else if (inc) cnt_d = cnt_q + W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign cnt  = cnt_q;
  assign last = (cnt_q == {W{1'b1}});
endmodule

// File: rtl/dmc_cache_ctrl.sv
module dmc_cache_ctrl
  import dmc_pkg::*;
#(
  parameter int TAG_W  = 8,
  parameter int IDX_W  = 3,
  parameter int OFF_W  = 5,
  parameter int DATA_W = 8,
  localparam int ADDR_W = TAG_W + IDX_W + OFF_W,
  localparam int RAM_AW = IDX_W + OFF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_cs,
  input  logic              cpu_wr,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic              cpu_rdy,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  input  logic              mem_ack,
  output logic [RAM_AW-1:0] ram_addr,
  output logic [DATA_W-1:0] ram_din,
  output logic              ram_wen,
  input  logic [DATA_W-1:0] ram_dout
);
  ctl_state_e st_q, st_d;
  logic              cs_q;
  logic [ADDR_W-1:0] addr_q;
  logic              wr_q;
  logic [DATA_W-1:0] wdata_q;
  logic [DATA_W-1:0] rdata_q;
  logic              cap_en, rcap_en;
  logic              cnt_inc, cnt_last;
  logic [OFF_W-1:0]  cnt;
  logic              fill_en, mark_en;
  logic [TAG_W-1:0]  st_tag;
  logic              st_valid, st_dirty, hit;

  logic [TAG_W-1:0] tag_q;
  logic [IDX_W-1:0] idx_q;
  logic [OFF_W-1:0] off_q;
  assign tag_q = addr_q[ADDR_W-1 -: TAG_W];
  assign idx_q = addr_q[OFF_W +: IDX_W];
  assign off_q = addr_q[OFF_W-1:0];

  dmc_tag_store #(.TAG_W(TAG_W), .IDX_W(IDX_W)) u_tags (
    .clk(clk), .rst_n(rst_n),
    .rd_idx(idx_q), .rd_tag(st_tag), .rd_valid(st_valid), .rd_dirty(st_dirty),
    .fill_en(fill_en), .fill_idx(idx_q), .fill_tag(tag_q),
    .mark_en(mark_en), .mark_idx(idx_q)
  );

  dmc_beat_cnt #(.W(OFF_W)) u_beat (
    .clk(clk), .rst_n(rst_n), .clr(st_q == S_IDLE), .inc(cnt_inc),
    .cnt(cnt), .last(cnt_last)
  );

  assign hit = st_valid && (st_tag == tag_q);

  // next-state and per-cycle controls
  always_comb begin
    st_d    = st_q;
    cap_en  = 1'b0;
    rcap_en = 1'b0;
    cnt_inc = 1'b0;
    fill_en = 1'b0;
    mark_en = 1'b0;
    ram_wen = 1'b0;
    mem_req = 1'b0;
    mem_we  = 1'b0;
    case (st_q)
      S_IDLE: if (cpu_cs && !cs_q) begin
        cap_en = 1'b1;
        st_d   = S_LOOK;
      end
      S_LOOK: begin
        if (hit) begin
          if (wr_q) begin
            ram_wen = 1'b1;
            mark_en = 1'b1;
            st_d    = S_IDLE;
          end else begin
            st_d = S_RDCAP;
          end
        end else if (st_valid && st_dirty) begin
          st_d = S_WBPRE;
        end else begin
          st_d = S_FILL;
        end
      end
      S_RDCAP: begin
        rcap_en = 1'b1;
        st_d    = S_IDLE;
      end
      S_WBPRE: st_d = S_WBREQ;
      S_WBREQ: begin
        mem_req = 1'b1;
        mem_we  = 1'b1;
        if (mem_ack) begin
          cnt_inc = 1'b1;
          st_d    = cnt_last ? S_FILL : S_WBPRE;
        end
      end
      S_FILL: begin
        mem_req = 1'b1;
        if (mem_ack) begin
          ram_wen = 1'b1;
          cnt_inc = 1'b1;
          if (cnt_last) begin
            fill_en = 1'b1;
            st_d    = S_LOOK;
          end
        end
      end
      default: st_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= S_IDLE;
      cs_q <= 1'b0;
    end else begin
      st_q <= st_d;
      cs_q <= cpu_cs;
    end
  end

  always_ff @(posedge clk) begin
    if (cap_en) begin
      addr_q  <= cpu_addr;
      wr_q    <= cpu_wr;
      wdata_q <= cpu_wdata;
    end
    if (rcap_en) rdata_q <= ram_dout;
  end

  logic in_xfer;
  assign in_xfer   = (st_q == S_WBPRE) || (st_q == S_WBREQ) || (st_q == S_FILL);
  assign ram_addr  = in_xfer ? {idx_q, cnt} : {idx_q, off_q};
  assign ram_din   = (st_q == S_FILL) ? mem_rdata : wdata_q;
  assign mem_addr  = {((st_q == S_FILL) ? tag_q : st_tag), idx_q, cnt};
  assign mem_wdata = ram_dout;
  assign cpu_rdy   = (st_q == S_IDLE);
  assign cpu_rdata = rdata_q;

  assert_accept_drops_rdy_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_rdy && cpu_cs && !cs_q) |=> !cpu_rdy);
  assert_req_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> mem_req && $stable(mem_addr) && $stable(mem_we));
  assert_wdata_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we && !mem_ack) |=> $stable(mem_wdata));
  assert_no_ram_write_in_wb_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we) |-> !ram_wen);
  assert_fill_offset_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ram_wen && mem_req) |-> ram_addr == mem_addr[RAM_AW-1:0]);
  assert_write_hit_latency_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == S_LOOK && hit && wr_q) |=> cpu_rdy);
  assert_read_hit_latency_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == S_LOOK && hit && !wr_q) |=> !cpu_rdy ##1 cpu_rdy);
endmodule

// File: tb/dmc_cache_ctrl_tb.sv
module dmc_cache_ctrl_tb;
  logic clk = 1'b0;
  logic rst_n;
  always #2 clk = ~clk;

  logic        cpu_cs, cpu_wr, cpu_rdy;
  logic [15:0] cpu_addr;
  logic [7:0]  cpu_wdata, cpu_rdata;
  logic        mem_req, mem_we, mem_ack;
  logic [15:0] mem_addr;
  logic [7:0]  mem_wdata, mem_rdata;
  logic [7:0]  ram_addr, ram_din, ram_dout;
  logic        ram_wen;

  dmc_cache_ctrl u_dut (
    .clk(clk), .rst_n(rst_n),
    .cpu_cs(cpu_cs), .cpu_wr(cpu_wr), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_rdata(cpu_rdata), .cpu_rdy(cpu_rdy),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .mem_ack(mem_ack),
    .ram_addr(ram_addr), .ram_din(ram_din), .ram_wen(ram_wen), .ram_dout(ram_dout)
  );

  int total = 0;
  int fails = 0;

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", rq, act, exp);
    end
  endtask

  // background contents of main memory
  function automatic logic [7:0] bg(input logic [15:0] a);
    return a[7:0] ^ {a[12:8], a[15:13]} ^ 8'h3C;
  endfunction

  logic [7:0] mm  [int];
  logic [7:0] arch[int];
  function automatic logic [7:0] mm_rd(input logic [15:0] a);
    return mm.exists(int'(a)) ? mm[int'(a)] : bg(a);
  endfunction
  function automatic logic [7:0] arch_rd(input logic [15:0] a);
    return arch.exists(int'(a)) ? arch[int'(a)] : bg(a);
  endfunction

  // line RAM model: one-cycle read latency
  logic [7:0] ram_mem [256];
  always @(posedge clk) begin
    if (ram_wen) ram_mem[ram_addr] <= ram_din;
    ram_dout <= ram_mem[ram_addr];
  end

  // main-memory model with random stalls
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_ack   <= 1'b0;
      mem_rdata <= 8'h00;
    end else begin
      mem_ack <= mem_req && !mem_ack && ($urandom_range(3) != 0);
      if (mem_req && !mem_ack) mem_rdata <= mm_rd(mem_addr);
    end
  end

  // transfer monitor
  int wr_n, rd_n, seq_err, drop_err;
  logic [15:0] wr_first, rd_first, wr_last, rd_last;
  logic prev_pend;
  always @(posedge clk) begin
    if (rst_n) begin
      if (prev_pend && !mem_req) drop_err++;
      prev_pend = mem_req && !mem_ack;
      if (mem_req && mem_ack) begin
        if (mem_we) begin
          if (wr_n == 0) wr_first = mem_addr;
          else if (mem_addr != wr_last + 16'd1) seq_err++;
          wr_last = mem_addr;
          wr_n++;
          mm[int'(mem_addr)] = mem_wdata;
        end else begin
          if (rd_n == 0) rd_first = mem_addr;
          else if (mem_addr != rd_last + 16'd1) seq_err++;
          rd_last = mem_addr;
          rd_n++;
        end
      end
    end else begin
      prev_pend = 1'b0;
    end
  end

  // reference line state
  logic [7:0] m_tag [8];
  bit         m_val [8];
  bit         m_dty [8];

  task automatic txn(input bit wr, input logic [15:0] a, input logic [7:0] d, input string dlab);
    logic [2:0]  idx;
    logic [7:0]  tg;
    bit          hit, exp_wb, rdy1_bad, retrig;
    logic [15:0] wb_base, rf_base;
    int          cyc, lat;
    idx = a[7:5];
    tg  = a[15:8];
    hit = m_val[idx] && (m_tag[idx] == tg);
    exp_wb  = !hit && m_val[idx] && m_dty[idx];
    wb_base = {m_tag[idx], idx, 5'd0};
    rf_base = {tg, idx, 5'd0};
    @(negedge clk);
    wr_n = 0; rd_n = 0; seq_err = 0;
    cpu_addr = a; cpu_wr = wr; cpu_wdata = d; cpu_cs = 1'b1;
    cyc = 0; lat = 0; rdy1_bad = 0; retrig = 0;
    while (1) begin
      @(negedge clk);
      cyc++;
      if (cyc == 1 && cpu_rdy) rdy1_bad = 1;
      else if (cpu_rdy && lat == 0) lat = cyc;
      else if (!cpu_rdy && lat != 0) retrig = 1;
      if (cyc == 4) cpu_cs = 1'b0;
      if ((cyc >= 4 && lat != 0) || cyc > 4000) break;
    end
    chk(!rdy1_bad, "R3 ready low after accept", int'(rdy1_bad), 0);
    chk(!retrig, "R3 held strobe retrigger", int'(retrig), 0);
    chk(seq_err == 0, "R6 ascending burst", seq_err, 0);
    if (hit) begin
      chk(wr_n == 0 && rd_n == 0, wr ? "R4 write hit traffic" : "R5 read hit traffic", wr_n + rd_n, 0);
      chk(lat == (wr ? 2 : 3), "R10 hit latency", lat, wr ? 2 : 3);
    end else begin
      chk(rd_n == 32, "R6 refill count", rd_n, 32);
      chk(rd_first == rf_base, "R2 refill base", int'(rd_first), int'(rf_base));
      chk(wr_n == (exp_wb ? 32 : 0), "R7 write-back count", wr_n, exp_wb ? 32 : 0);
      if (exp_wb) chk(wr_first == wb_base, "R7 write-back base", int'(wr_first), int'(wb_base));
    end
    if (!wr) chk(cpu_rdata == arch_rd(a), dlab, int'(cpu_rdata), int'(arch_rd(a)));
    if (!hit) begin
      m_tag[idx] = tg;
      m_val[idx] = 1;
      m_dty[idx] = 0;
    end
    if (wr) begin
      m_dty[idx] = 1;
      arch[int'(a)] = d;
    end
  endtask

  initial begin
    int cyc = 0;
    while (cyc < 150000) begin
      @(posedge clk);
      cyc++;
    end
    chk(0, "watchdog", cyc, 0);
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    for (int i = 0; i < 8; i++) begin m_val[i] = 0; m_dty[i] = 0; m_tag[i] = 8'h00; end
    wr_n = 0; rd_n = 0; seq_err = 0; drop_err = 0;
    cpu_cs = 0; cpu_wr = 0; cpu_addr = 16'h0; cpu_wdata = 8'h0;
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(cpu_rdy == 1'b1, "R1 ready after reset", int'(cpu_rdy), 1);
    chk(mem_req == 1'b0, "R1 no request after reset", int'(mem_req), 0);

    // directed corner cases
    txn(0, 16'h1203, 8'h00, "R6 clean read miss data");
    chk(rd_n == 32, "R1 first access fetches", rd_n, 32);
    txn(0, 16'h121F, 8'h00, "R5 read hit offset 31");
    txn(1, 16'h1200, 8'hA5, "unused");
    txn(0, 16'h1200, 8'h00, "R4 written byte read back");
    txn(0, 16'h3401, 8'h00, "R7 read after dirty eviction");
    txn(0, 16'h1200, 8'h00, "R7 written-back byte restored");
    txn(1, 16'hFFFF, 8'h5A, "unused");
    txn(0, 16'hFFFF, 8'h00, "R8 merged byte after write miss");
    txn(0, 16'hFFE0, 8'h00, "R8 refilled neighbour");
    txn(1, 16'h00E0, 8'hC3, "unused");
    txn(0, 16'hFFE5, 8'h00, "R7 dirty victim tag FF refill");
    txn(0, 16'hFFFF, 8'h00, "R7 tag FF byte survived eviction");

    // constrained random traffic over a few tags per index
    for (int n = 0; n < 300; n++) begin
      logic [15:0] a;
      bit w;
      a = {6'h00, 2'($urandom_range(3)), 3'($urandom_range(7)), 5'($urandom_range(31))};
      w = ($urandom_range(1) == 1);
      txn(w, a, 8'($urandom), "R5 random read data");
    end
    chk(drop_err == 0, "R9 request dropped before ack", drop_err, 0);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule